// File: doc/BRIEF.md
# Paged Open-Drain GPIO Register Bank

This block is a byte-wide register file that drives and samples 48 general-purpose I/O lines, grouped as six 8-bit ports, through a 16-byte address window. Every line is open-drain. A 1 written to a port bit turns on that pin's current sink and pulls it low. A 0 releases the pin to high impedance, so an external pull-up can raise it and the line can serve as an input. A port read returns the inverted, synchronised pin level, so a released pin that is pulled high reads as 0.

The six port registers and a pending-status byte can be reached on every page. One control byte selects a page and also holds one write-lock bit for each port. The three bytes above the control byte are a window onto the selected page: edge polarity, interrupt enable, or interrupt identification. The page-0 window is empty. The edge-detect logic that sits next to this block takes the polarity and enable words from it, along with the synchronised pins. It returns one-cycle hit pulses, which collect in the identification register until software clears them.

Top module: `gpio_paged_bank`

## Requirements
- R1: After reset, all sink enables are 0 (every pin released), the control byte reads 0x00, and the polarity, enable and identification words are all zero.
- R2: A write to offsets 0x00–0x05 loads the sink-enable byte of port N = offset (1 = sink, pulls the pin low). This works on any selected page, and only port writes change the sink enables.
- R3: A read of offsets 0x00–0x05 returns the bitwise inverse of that port's synchronised pin byte, and not the written sink value.
- R4: Offset 0x07 is the control byte. Bits 7:6 select the page (0 empty, 1 polarity, 2 enable, 3 identification) and bits 5:0 are the lock bits for ports 0–5. Reading it returns the last value written.
- R5: While a port's lock bit is set, writes to that port's data offset leave its sink enables unchanged. Writes to unlocked ports still take effect.
- R6: Offsets 0x08, 0x09 and 0x0A access bytes 0, 1 and 2 of the selected page's 24-bit word. The polarity and enable words drive the edge_pol and edge_en outputs, and a write reaches only the selected page.
- R7: A 1 on any edge_hit bit sets the matching identification bit one cycle later. The bit stays set until software writes that byte, and the written value then replaces the byte.
- R8: Offset 0x06 reads bit k = 1 when identification byte k has any bit set, for k = 0..2. Bits 7:3 read 0.
- R9: With page 0 selected, offsets 0x08–0x0A read 0x00. Offsets 0x0B–0x0F read 0x00 on every page. Writes to any of these locations change no state.
- R10: Each pin input passes through two flip-flops that reset to 1. pin_sync equals pin_in as it was two clock edges earlier, and port readback changes on the second edge after a pin changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Byte offset within the window |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pin_in | input | 48 | Raw pin levels |
| pin_sink | output | 48 | Sink enables, 1 pulls the pin low |
| pin_sync | output | 48 | Synchronised pin levels for edge detection |
| edge_pol | output | 24 | Polarity word (page 1) |
| edge_en | output | 24 | Interrupt-enable word (page 2) |
| edge_hit | input | 24 | Edge pulses that set identification bits |

## Verification
The assertions assume that the bus does at most one access per cycle, and that the edge-detect neighbour pulses edge_hit only while reset is released. The read properties take bus_addr to be steady around the sampling edge. The bench drives every input on the falling clock edge and gives each write a full cycle. It keeps edge_hit low during any cycle that writes the identification page, so the sticky-set and software-clear paths are each checked on their own.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 4;
    localparam int LOCK_BITS = 6;
    localparam int OFF_PEND  = 6;
    localparam int OFF_CTRL  = 7;
    localparam int OFF_EXT0  = 8;

    typedef enum logic [1:0] {
        PG_NONE = 2'd0,
        PG_POL  = 2'd1,
        PG_IEN  = 2'd2,
        PG_IID  = 2'd3
    } page_e;
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
    parameter int WIDTH = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] synced
);
    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d        = sy_q;
        sy_d.meta   = raw;
        sy_d.stable = sy_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sy_q <= '1;
        end else begin
            sy_q <= sy_d;
        end
    end

    assign synced = sy_q.stable;
endmodule

// File: rtl/gpio_bank_extreg.sv
module gpio_bank_extreg #(
    parameter int BYTES = 3,
    localparam int WIDTH = BYTES * 8,
    localparam int SEL_W = (BYTES > 1) ? $clog2(BYTES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [7:0]       wr_data,
    input  logic [WIDTH-1:0] set_bits,
    output logic [WIDTH-1:0] value
);
    logic [WIDTH-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (wr_en) begin
            val_d[int'(wr_sel)*8 +: 8] = wr_data;
        end
        val_d = val_d | set_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q <= '0;
        end else begin
            val_q <= val_d;
        end
    end

    assign value = val_q;
endmodule

// File: rtl/gpio_bank_rdmux.sv
module gpio_bank_rdmux
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PORTS = 6,
    parameter int EXT_BYTES = 3,
    localparam int PIN_W = NUM_PORTS * 8,
    localparam int EXT_W = EXT_BYTES * 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  page_e             page,
    input  logic [PIN_W-1:0]  pins,
    input  logic [7:0]        ctrl_byte,
    input  logic [7:0]        pend_byte,
    input  logic [EXT_W-1:0]  pol_word,
    input  logic [EXT_W-1:0]  ien_word,
    input  logic [EXT_W-1:0]  iid_word,
    output logic [7:0]        rdata
);
    int addr_i;
    int ext_i;
    assign addr_i = 32'(addr);
    assign ext_i  = addr_i - OFF_EXT0;

    always_comb begin
        rdata = '0;
        if (addr_i < NUM_PORTS) begin
            rdata = ~pins[addr_i*8 +: 8];
        end else if (addr_i == OFF_PEND) begin
            rdata = pend_byte;
        end else if (addr_i == OFF_CTRL) begin
            rdata = ctrl_byte;
        end else if (addr_i >= OFF_EXT0 && ext_i < EXT_BYTES) begin
            unique case (page)
                PG_POL:  rdata = pol_word[ext_i*8 +: 8];
                PG_IEN:  rdata = ien_word[ext_i*8 +: 8];
                PG_IID:  rdata = iid_word[ext_i*8 +: 8];
                default: rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_paged_bank.sv
module gpio_paged_bank
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PORTS = 6,
    parameter int EXT_BYTES = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [3:0]              bus_addr,
    input  logic                    bus_wr,
    input  logic [7:0]              bus_wdata,
    output logic [7:0]              bus_rdata,
    input  logic [NUM_PORTS*8-1:0]  pin_in,
    output logic [NUM_PORTS*8-1:0]  pin_sink,
    output logic [NUM_PORTS*8-1:0]  pin_sync,
    output logic [EXT_BYTES*8-1:0]  edge_pol,
    output logic [EXT_BYTES*8-1:0]  edge_en,
    input  logic [EXT_BYTES*8-1:0]  edge_hit
);
    localparam int PIN_W     = NUM_PORTS * 8;
    localparam int EXT_W     = EXT_BYTES * 8;
    localparam int IDX_W     = $clog2(NUM_PORTS);
    localparam int EXT_SEL_W = (EXT_BYTES > 1) ? $clog2(EXT_BYTES) : 1;
    localparam int NUM_PAGES = 4;

    typedef struct packed {
        logic [PIN_W-1:0]     sink;
        page_e                page;
        logic [NUM_PORTS-1:0] lock;
    } bank_t;

    bank_t st_d, st_q;

    int                   addr_i;
    logic                 port_hit;
    logic                 ext_hit;
    logic [IDX_W-1:0]     port_idx;
    logic [EXT_SEL_W-1:0] ext_sel;
    logic [EXT_W-1:0]     page_word [NUM_PAGES];
    logic [EXT_W-1:0]     id_q;
    logic [NUM_PORTS-1:0] lock_q;
    logic [1:0]           page_q;
    logic [LOCK_BITS-1:0] lock_pad;
    logic [7:0]           ctrl_byte;
    logic [7:0]           pend_byte;

    assign addr_i   = 32'(bus_addr);
    assign port_hit = addr_i < NUM_PORTS;
    assign ext_hit  = (addr_i >= OFF_EXT0) && (addr_i < OFF_EXT0 + EXT_BYTES);
    assign port_idx = IDX_W'(bus_addr);
    assign ext_sel  = EXT_SEL_W'(addr_i - OFF_EXT0);

    always_comb begin
        st_d = st_q;
        if (bus_wr) begin
            if (addr_i == OFF_CTRL) begin
                st_d.page = page_e'(bus_wdata[7:6]);
                st_d.lock = bus_wdata[NUM_PORTS-1:0];
            end else if (port_hit && !st_q.lock[port_idx]) begin
                st_d.sink[int'(port_idx)*8 +: 8] = bus_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sink: '0, page: PG_NONE, lock: '0};
        end else begin
            st_q <= st_d;
        end
    end

    gpio_bank_sync #(.WIDTH(PIN_W)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (pin_in),
        .synced (pin_sync)
    );

    assign page_word[0] = '0;

    for (genvar g = 1; g < NUM_PAGES; g++) begin : g_page
        logic [EXT_W-1:0] set_src;
        if (g == int'(PG_IID)) begin : g_sticky
            assign set_src = edge_hit;
        end else begin : g_plain
            assign set_src = '0;
        end
        gpio_bank_extreg #(.BYTES(EXT_BYTES)) u_reg (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (bus_wr && ext_hit && (st_q.page == page_e'(g))),
            .wr_sel   (ext_sel),
            .wr_data  (bus_wdata),
            .set_bits (set_src),
            .value    (page_word[g])
        );
    end

    assign id_q = page_word[PG_IID];

    always_comb begin
        pend_byte = '0;
        for (int b = 0; b < EXT_BYTES; b++) begin
            pend_byte[b] = |id_q[b*8 +: 8];
        end
    end

    assign lock_q    = st_q.lock;
    assign page_q    = st_q.page;
    assign lock_pad  = LOCK_BITS'(st_q.lock);
    assign ctrl_byte = {page_q, lock_pad};

    gpio_bank_rdmux #(.NUM_PORTS(NUM_PORTS), .EXT_BYTES(EXT_BYTES)) u_rdmux (
        .addr      (bus_addr),
        .page      (st_q.page),
        .pins      (pin_sync),
        .ctrl_byte (ctrl_byte),
        .pend_byte (pend_byte),
        .pol_word  (page_word[PG_POL]),
        .ien_word  (page_word[PG_IEN]),
        .iid_word  (page_word[PG_IID]),
        .rdata     (bus_rdata)
    );

    assign pin_sink = st_q.sink;
    assign edge_pol = page_word[PG_POL];
    assign edge_en  = page_word[PG_IEN];
endmodule

// File: rtl/gpio_paged_bank_chk.sv
module gpio_paged_bank_chk #(
    parameter int NUM_PORTS = 6,
    parameter int EXT_BYTES = 3,
    localparam int PIN_W = NUM_PORTS * 8,
    localparam int EXT_W = EXT_BYTES * 8,
    localparam int IDX_W = $clog2(NUM_PORTS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [3:0]           bus_addr,
    input logic                 bus_wr,
    input logic [7:0]           bus_rdata,
    input logic [PIN_W-1:0]     pin_in,
    input logic [PIN_W-1:0]     pin_sync,
    input logic [PIN_W-1:0]     pin_sink,
    input logic [EXT_W-1:0]     edge_pol,
    input logic [EXT_W-1:0]     edge_en,
    input logic [EXT_W-1:0]     edge_hit,
    input logic [NUM_PORTS-1:0] lock,
    input logic [1:0]           page,
    input logic [EXT_W-1:0]     id_bits
);
    int addr_i;
    logic is_port;
    logic is_ext;
    logic [1:0] age;

    assign addr_i  = 32'(bus_addr);
    assign is_port = addr_i < NUM_PORTS;
    assign is_ext  = (addr_i >= 8) && (addr_i < 8 + EXT_BYTES);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age <= '0;
        end else if (age != 2'd2) begin
            age <= age + 2'd1;
        end
    end

    assert_locked_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && is_port && lock[IDX_W'(bus_addr)]) |=> $stable(pin_sink));

    assert_sink_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && is_port) |=> $stable(pin_sink));

    assert_readback_R3: assert property (@(posedge clk) disable iff (!rst_n)
        is_port |-> (bus_rdata == ~pin_sync[addr_i*8 +: 8]));

    assert_sync_delay_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2) |-> (pin_sync == $past(pin_in, 2)));

    assert_pend_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == 6) |-> ((bus_rdata[7:EXT_BYTES] == '0) && ((|bus_rdata) == (|id_bits))));

    assert_hole_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i >= 8 + EXT_BYTES) |-> (bus_rdata == 8'h00));

    assert_page0_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ext && page == 2'd0) |-> (bus_rdata == 8'h00));

    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|edge_hit) |=> ((id_bits & $past(edge_hit)) == $past(edge_hit)));

    assert_ien_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(edge_en) |-> $past(bus_wr && is_ext && page == 2'd2));

    assert_pol_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(edge_pol) |-> $past(bus_wr && is_ext && page == 2'd1));
endmodule

bind gpio_paged_bank gpio_paged_bank_chk #(
    .NUM_PORTS(NUM_PORTS),
    .EXT_BYTES(EXT_BYTES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_sync  (pin_sync),
    .pin_sink  (pin_sink),
    .edge_pol  (edge_pol),
    .edge_en   (edge_en),
    .edge_hit  (edge_hit),
    .lock      (lock_q),
    .page      (page_q),
    .id_bits   (id_q)
);

// File: tb/gpio_paged_bank_tb.sv
module gpio_paged_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [47:0] pin_in = '1;
    logic [47:0] pin_sink;
    logic [47:0] pin_sync;
    logic [23:0] edge_pol;
    logic [23:0] edge_en;
    logic [23:0] edge_hit = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    gpio_paged_bank u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_sink  (pin_sink),
        .pin_sync  (pin_sync),
        .edge_pol  (edge_pol),
        .edge_en   (edge_en),
        .edge_hit  (edge_hit)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1 sink", 64'(pin_sink), 64'h0);
        check("R1 pol", 64'(edge_pol), 64'h0);
        check("R1 en", 64'(edge_en), 64'h0);
        rd(4'h7, v); check("R1 ctrl", 64'(v), 64'h00);
        rd(4'h6, v); check("R1 pend", 64'(v), 64'h00);
        rd(4'h0, v); check("R1 port0 released", 64'(v), 64'h00);
    endtask

    task automatic t_port_write();
        logic [7:0] v;
        wr(4'h0, 8'hA5);
        check("R2 port0 sink", 64'(pin_sink[7:0]), 64'hA5);
        wr(4'h7, 8'hC0);
        wr(4'h5, 8'h3C);
        check("R2 port5 on page3", 64'(pin_sink[47:40]), 64'h3C);
        rd(4'h5, v); check("R3 read is pin not sink", 64'(v), 64'h00);
        wr(4'h7, 8'h00);
    endtask

    task automatic t_readback();
        logic [7:0] v;
        pin_in[15:8] = 8'h0F;
        rd(4'h1, v); check("R10 no change before edge", 64'(v), 64'h00);
        @(negedge clk);
        rd(4'h1, v); check("R10 one edge still old", 64'(v), 64'h00);
        @(negedge clk);
        rd(4'h1, v); check("R3 inverted readback", 64'(v), 64'hF0);
        check("R10 pin_sync", 64'(pin_sync[15:8]), 64'h0F);
        pin_in[15:8] = 8'hFF;
        repeat (2) @(negedge clk);
        rd(4'h1, v); check("R3 released reads zero", 64'(v), 64'h00);
    endtask

    task automatic t_ctrl();
        logic [7:0] v;
        wr(4'h7, 8'h95);
        rd(4'h7, v); check("R4 ctrl readback", 64'(v), 64'h95);
        wr(4'h7, 8'h00);
    endtask

    task automatic t_lock();
        logic [7:0] v;
        wr(4'h7, 8'h04);
        wr(4'h2, 8'hFF);
        check("R5 locked port2", 64'(pin_sink[23:16]), 64'h00);
        wr(4'h3, 8'h81);
        check("R5 unlocked port3", 64'(pin_sink[31:24]), 64'h81);
        rd(4'h7, v); check("R4 lock bits", 64'(v), 64'h04);
        wr(4'h7, 8'h00);
        wr(4'h2, 8'hFF);
        check("R5 after unlock", 64'(pin_sink[23:16]), 64'hFF);
    endtask

    task automatic t_paged();
        logic [7:0] v;
        wr(4'h7, 8'h40);
        wr(4'h8, 8'h11);
        wr(4'h9, 8'h22);
        wr(4'hA, 8'h33);
        check("R6 pol word", 64'(edge_pol), 64'h332211);
        check("R6 en untouched", 64'(edge_en), 64'h0);
        rd(4'h9, v); check("R6 pol byte1", 64'(v), 64'h22);
        wr(4'h7, 8'h80);
        wr(4'h8, 8'hAA);
        check("R6 en word", 64'(edge_en), 64'h0000AA);
        check("R6 pol untouched", 64'(edge_pol), 64'h332211);
        rd(4'h8, v); check("R6 en byte0", 64'(v), 64'hAA);
    endtask

    task automatic t_idreg();
        logic [7:0] v;
        wr(4'h7, 8'hC0);
        edge_hit = 24'h000200;
        @(negedge clk);
        edge_hit = '0;
        rd(4'h9, v); check("R7 id set", 64'(v), 64'h02);
        rd(4'h8, v); check("R7 id byte0 clear", 64'(v), 64'h00);
        rd(4'h6, v); check("R8 pend byte1", 64'(v), 64'h02);
        edge_hit = 24'h100000;
        @(negedge clk);
        edge_hit = '0;
        @(negedge clk);
        rd(4'h9, v); check("R7 sticky", 64'(v), 64'h02);
        rd(4'h6, v); check("R8 pend two bytes", 64'(v), 64'h06);
        wr(4'h9, 8'h00);
        rd(4'h9, v); check("R7 clear by write", 64'(v), 64'h00);
        rd(4'h6, v); check("R8 pend after clear", 64'(v), 64'h04);
        wr(4'hA, 8'h00);
        rd(4'h6, v); check("R8 pend empty", 64'(v), 64'h00);
    endtask

    task automatic t_holes();
        logic [7:0]  v;
        logic [47:0] sink_snap;
        sink_snap = pin_sink;
        wr(4'h7, 8'h00);
        rd(4'h8, v); check("R9 page0 read", 64'(v), 64'h00);
        wr(4'h8, 8'hFF);
        wr(4'h9, 8'hFF);
        check("R9 page0 write pol", 64'(edge_pol), 64'h332211);
        check("R9 page0 write en", 64'(edge_en), 64'h0000AA);
        wr(4'hC, 8'hFF);
        wr(4'hF, 8'hFF);
        check("R9 hole write sink", 64'(pin_sink), 64'(sink_snap));
        rd(4'h7, v); check("R9 hole write ctrl", 64'(v), 64'h00);
        rd(4'hC, v); check("R9 hole read C", 64'(v), 64'h00);
        wr(4'h7, 8'h40);
        rd(4'hB, v); check("R9 hole read B page1", 64'(v), 64'h00);
        check("R9 hole write pol", 64'(edge_pol), 64'h332211);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_port_write();
        t_readback();
        t_ctrl();
        t_lock();
        t_paged();
        t_idreg();
        t_holes();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule